// File: doc/BRIEF.md
# Mini-Slot Site Counter Arbiter

This block grants one station on a shared single-line bus the right to start a transmission, without collisions and without an explicit token message. Every station on the bus holds an identical copy of a site counter. The value of that counter names the one site that may begin sending during the current mini-slot. When the line stays quiet for a full mini-slot, every copy steps to the next site. When the named site starts sending, every copy freezes, and counting resumes one full mini-slot after the line goes quiet again. The token is handed on by silence, so no station can lose it.

Stations also correct drift between their copies. When a receiver outside this block decodes a frame and reports the sender's site number, the counter is loaded with that number. The sender is taken to have held permission. Line activity passes through a sample filter before it is treated as a transmission. The local transmitter watches the grant output and must begin its frame while the grant is high.

Top module: `mss_arbiter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, site_o is 0, busy_o is 0 and grant_o is 0.
- R2: While the line is quiet and no frame is reported, site_o increases by one every SLOT_CYCLES clock cycles, counted from reset release or from the last counter change.
- R3: An increase from site NUM_SITES-1 wraps to site 0.
- R4: busy_o rises on the clock edge that samples line_busy_i high for the DEB_SAMPLES-th consecutive time. A shorter high pulse leaves busy_o low and does not change when the next increase happens.
- R5: busy_o falls on the first edge that samples line_busy_i low.
- R6: While busy_o is high, site_o does not increase. The next increase comes SLOT_CYCLES cycles after the edge at which busy_o fell.
- R7: An edge that samples rx_valid_i high with rx_site_i below NUM_SITES loads site_o with rx_site_i and restarts the mini-slot. The next increase follows SLOT_CYCLES cycles later.
- R8: When a valid frame report and a slot expiry fall on the same edge, the reported site is loaded and the increase is dropped.
- R9: A frame report with rx_site_i at or above NUM_SITES is ignored: site_o and the slot timing are unchanged.
- R10: grant_o is high exactly when site_o equals local_site_i, tx_req_i is high and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_busy_i | input | 1 | Raw line-activity (carrier) sample |
| rx_valid_i | input | 1 | One-cycle strobe: a frame was decoded |
| rx_site_i | input | SITE_W | Sender site number of the decoded frame |
| local_site_i | input | SITE_W | Site number of this station |
| tx_req_i | input | 1 | Local transmitter has a frame waiting |
| grant_o | output | 1 | Local transmitter may start now |
| site_o | output | SITE_W | Current site counter value |
| busy_o | output | 1 | Filtered line activity |

## Verification
The bench runs a small configuration for several full counter revolutions and checks every cycle against arithmetic expectations. This catches a counter that wraps one site late or early, and a slot that is one cycle too long or too short. Line pulses one sample shorter than the filter length are injected. A filter that is off by one would raise busy and disturb the slot timing. Holding the line busy and then releasing it checks that the counter stays frozen and that the slot is measured from the release. A design that kept its old partial count would advance too early. Frame reports are placed on the expiry edge, which exposes a wrong priority that gives site+1 instead of the reported site. Out-of-range reports are also sent, and a design that accepted them would leave the counter outside its range or shift every later advance.

// File: rtl/mss_pkg.sv
package mss_pkg;
  // counter width for values 0..n-1, never below one bit
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mss_line_filter.sv
module mss_line_filter #(
  parameter int DEB_SAMPLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic busy_o
);
  localparam int CW = mss_pkg::cnt_w(DEB_SAMPLES);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!line_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (cnt_q == CW'(DEB_SAMPLES - 1)) busy_q <= 1'b1;
      else                                cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;

  AST_BUSY_NEEDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(line_i)); // R4
  AST_BUSY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> !busy_q); // R5
endmodule

// File: rtl/mss_slot_timer.sv
module mss_slot_timer #(
  parameter int SLOT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int TW = mss_pkg::cnt_w(SLOT_CYCLES);

  logic [TW-1:0] tmr_q;

  assign expire_o = !busy_i && (tmr_q == TW'(SLOT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            tmr_q <= '0;
    else if (busy_i || restart_i || expire_o) tmr_q <= '0;
    else                                    tmr_q <= tmr_q + 1'b1;
  end

  AST_TMR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tmr_q) < SLOT_CYCLES); // R2
  AST_TMR_CLEAR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> tmr_q == '0); // R6
endmodule

// File: rtl/mss_site_counter.sv
module mss_site_counter #(
  parameter int NUM_SITES = 100,
  parameter int SITE_W    = mss_pkg::cnt_w(NUM_SITES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SITE_W-1:0] load_site_i,
  input  logic              adv_i,
  output logic [SITE_W-1:0] site_o
);
  localparam logic [SITE_W-1:0] LAST = SITE_W'(NUM_SITES - 1);

  logic [SITE_W-1:0] site_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     site_q <= '0;
    else if (load_i) site_q <= load_site_i;   // resync wins over advance
    else if (adv_i)  site_q <= (site_q == LAST) ? '0 : site_q + 1'b1;
  end

  assign site_o = site_q;

  AST_SITE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(site_q) < NUM_SITES); // R9
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && site_q == LAST) |=> site_q == '0); // R3
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> site_q == $past(load_site_i)); // R8
endmodule

// File: rtl/mss_arbiter.sv
module mss_arbiter #(
  parameter int NUM_SITES   = 100,
  parameter int SLOT_CYCLES = 2_500_000,
  parameter int DEB_SAMPLES = 4,
  parameter int SITE_W      = mss_pkg::cnt_w(NUM_SITES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_busy_i,
  input  logic              rx_valid_i,
  input  logic [SITE_W-1:0] rx_site_i,
  input  logic [SITE_W-1:0] local_site_i,
  input  logic              tx_req_i,
  output logic              grant_o,
  output logic [SITE_W-1:0] site_o,
  output logic              busy_o
);
  logic busy;
  logic expire;
  logic load;
  logic [SITE_W-1:0] site;

  // out-of-range sender numbers are dropped
  assign load = rx_valid_i && (32'(rx_site_i) < NUM_SITES);

  mss_line_filter #(.DEB_SAMPLES(DEB_SAMPLES)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_busy_i),
    .busy_o(busy)
  );

  mss_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .restart_i(load),
    .expire_o (expire)
  );

  mss_site_counter #(.NUM_SITES(NUM_SITES), .SITE_W(SITE_W)) u_site (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_site_i(rx_site_i),
    .adv_i      (expire),
    .site_o     (site)
  );

  assign grant_o = (site == local_site_i) && tx_req_i && !busy;
  assign site_o  = site;
  assign busy_o  = busy;

  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !load) |=> $stable(site)); // R6
  AST_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> site == $past(rx_site_i)); // R7
  AST_NO_GRANT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !grant_o); // R10
endmodule

// File: tb/mss_arbiter_tb.sv
module mss_arbiter_tb_top;
  localparam int N    = 5;
  localparam int SLOT = 6;
  localparam int DEB  = 3;
  localparam int SW   = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          line_busy_i = 1'b0;
  logic          rx_valid_i = 1'b0;
  logic [SW-1:0] rx_site_i = '0;
  logic [SW-1:0] local_site_i = '0;
  logic          tx_req_i = 1'b0;
  logic          grant_o;
  logic [SW-1:0] site_o;
  logic          busy_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  mss_arbiter #(.NUM_SITES(N), .SLOT_CYCLES(SLOT), .DEB_SAMPLES(DEB), .SITE_W(SW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_busy_i(line_busy_i), .rx_valid_i(rx_valid_i),
    .rx_site_i(rx_site_i), .local_site_i(local_site_i), .tx_req_i(tx_req_i),
    .grant_o(grant_o), .site_o(site_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    line_busy_i = 0; rx_valid_i = 0; tx_req_i = 0;
    rst_ni = 0;
    step(); step();
    check("R1 site", int'(site_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 grant", int'(grant_o), 0);
    rst_ni = 1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    step();
    check("R1 site after release", int'(site_o), 0);

    // R2 R3 R10: free-run sweep over two revolutions
    do_reset();
    local_site_i = 2; tx_req_i = 1;
    for (int e = 1; e <= 2 * N * SLOT; e++) begin
      if (e > N * SLOT) tx_req_i = 0;
      step();
      check("R2 R3 site", int'(site_o), (e / SLOT) % N);
      check("R10 grant", int'(grant_o), (tx_req_i && ((e / SLOT) % N) == 2) ? 1 : 0);
    end

    // R4: short pulse filtered, timing undisturbed
    do_reset();
    step();
    line_busy_i = 1;
    for (int i = 1; i < DEB; i++) begin
      step();
      check("R4 short pulse busy", int'(busy_o), 0);
    end
    line_busy_i = 0;
    step();
    for (int e = DEB + 2; e <= 2 * SLOT; e++) begin
      step();
      check("R4 timing after glitch", int'(site_o), (e / SLOT) % N);
    end

    // R4 R5 R6 R10: hold while busy, slot measured from release
    do_reset();
    local_site_i = 0; tx_req_i = 1;
    step(); step();
    check("R10 grant idle", int'(grant_o), 1);
    line_busy_i = 1;
    for (int i = 1; i <= DEB; i++) begin
      step();
      check("R4 busy rise", int'(busy_o), (i == DEB) ? 1 : 0);
    end
    check("R10 grant blocked by busy", int'(grant_o), 0);
    for (int i = 0; i < 3 * SLOT; i++) begin
      step();
      check("R6 hold", int'(site_o), 0);
    end
    line_busy_i = 0;
    step();
    check("R5 busy fall", int'(busy_o), 0);
    for (int i = 1; i <= SLOT; i++) begin
      step();
      check("R6 advance after release", int'(site_o), (i == SLOT) ? 1 : 0);
    end
    tx_req_i = 0;

    // R7 R3: resync restarts slot
    do_reset();
    step(); step();
    rx_valid_i = 1; rx_site_i = 3;
    step();
    rx_valid_i = 0;
    check("R7 load", int'(site_o), 3);
    for (int i = 1; i <= 2 * SLOT; i++) begin
      step();
      check("R7 R3 after resync", int'(site_o), (3 + i / SLOT) % N);
    end

    // R8: resync on the expiry edge
    do_reset();
    for (int i = 1; i < SLOT; i++) step();
    rx_valid_i = 1; rx_site_i = 4;
    step();
    rx_valid_i = 0;
    check("R8 load beats advance", int'(site_o), 4);
    for (int i = 1; i <= SLOT; i++) begin
      step();
      check("R8 after", int'(site_o), (4 + i / SLOT) % N);
    end

    // R9: out-of-range report ignored
    do_reset();
    step(); step();
    rx_valid_i = 1; rx_site_i = 7;
    step();
    rx_valid_i = 0;
    check("R9 ignored", int'(site_o), 0);
    for (int e = 4; e <= 2 * SLOT; e++) begin
      step();
      check("R9 timing kept", int'(site_o), (e / SLOT) % N);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule